// File: doc/BRIEF.md
# Bank-Set Precharge Pacer

This block decides when a memory controller may send precharge commands to a DRAM organised as two bank sets. Two request lanes each offer one precharge at a time with a valid/ready handshake. Each request carries a target bank set and a kind: an ordinary precharge or a refresh precharge. The block grants a request on the clock edge where every spacing rule that applies to it is met. The granted work appears one cycle later as a row-precharge packet. The packet has one slot per bank set, so it can carry two independent precharges at once.

Two spacing limits apply. `T_SAME` is the minimum distance between precharges to one bank set. `T_CROSS` is a separate, usually smaller, minimum distance between precharges to different bank sets. With a small `T_CROSS`, a precharge to one set can be placed between two precharges to the other set. With `T_CROSS` equal to 0, two precharges to different sets can share a single packet and take effect on the same edge. The `ZERO_EN` parameter can forbid that mode, which raises the effective cross-set distance to 1. With `DUAL_SET` cleared, the device is treated as having a single bank set and only the same-set limit applies.

Top module: `prech_pacer`

## Requirements
- R1: Two grants to the same bank set are at least `T_SAME` cycles apart (the default is 4). A request that waits on this limit is granted exactly `T_SAME` cycles after the previous grant to its set.
- R2: Two grants to different bank sets in separate packets are at least `T_CROSS` cycles apart, where `T_CROSS` is 0, 1, 2 or 4. Back-to-back requests on one lane to alternating sets are granted max(`T_CROSS`,1) cycles apart.
- R3: With `T_CROSS` of 1 or 2, the request sequence set 0, set 1, set 0 on one lane is granted at offsets 0, `T_CROSS`, `T_SAME`. The middle grant is therefore not centred when `T_CROSS` is 1.
- R4: With `T_CROSS` of 4, the sequence set 0, set 1, set 0 is granted at offsets 0, 4, 8, which is the same spacing as the same-set rule.
- R5: When `T_CROSS` is 0, `ZERO_EN` is 1, and both lanes hold eligible requests to different sets, both requests are granted on the same edge and travel in one packet with both slots filled.
- R6: When `ZERO_EN` is 0, a `T_CROSS` of 0 behaves as 1. Simultaneous requests to different sets are granted one cycle apart in two packets.
- R7: Two requests to the same bank set are never merged. The second one is granted `T_SAME` cycles after the first.
- R8: When `DUAL_SET` is 0, the set bit is ignored. Every grant uses slot 0 and follows the `T_SAME` spacing.
- R9: When both lanes are eligible and only one can be granted, the request that has waited longer is granted first. If both have waited equally long, a refresh precharge (kind 1) wins over an ordinary precharge (kind 0). If both are the same kind, lane 0 wins.
- R10: A grant raises `req_ready` only for a lane whose `req_valid` is high. On the next cycle `pkt_valid` is 1, `pkt_pre[s]` is 1 for each bank set s that received a grant, and `pkt_kind[s]` carries that grant's kind. In any cycle after no grant, `pkt_valid` is 0.
- R11: During and after reset, `pkt_valid` is 0 and all spacing counters are clear. The first request after reset is therefore granted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request present, one bit per lane |
| req_set | input | 2 | Target bank set, one bit per lane |
| req_kind | input | 2 | Kind per lane: 0 for an ordinary precharge, 1 for a refresh precharge |
| req_ready | output | 2 | Grant; the request is taken on this edge |
| pkt_valid | output | 1 | A packet is being sent this cycle |
| pkt_pre | output | 2 | Precharge present in the slot for bank set s |
| pkt_kind | output | 2 | Kind of the precharge in the slot for bank set s |

## Verification
The spacing assertions assume that a request, once raised, keeps its set and kind until it is granted. They also assume that `T_SAME` is at least 4 and below 255, so that the saturating gap counters in the checker can hold any legal spacing. The bench respects both assumptions. It changes lane inputs only on the falling edge, drops `req_valid` only after the edge on which `req_ready` was seen, and uses a `T_SAME` of 4 on every instance. Six instances cover every allowed `T_CROSS` value, the disabled zero-cycle mode and the single-set mode, so the gap assertions see each setting.

// File: rtl/prech_pacer_pkg.sv
package prech_pacer_pkg;

  localparam logic KIND_NORM = 1'b0;
  localparam logic KIND_REFR = 1'b1;

  // Effective cross-set spacing once the zero-cycle mode is considered.
  function automatic int eff_cross(input int t_cross, input int zero_en);
    return (t_cross == 0 && zero_en == 0) ? 1 : t_cross;
  endfunction

  // Value loaded into a down-counter so that the next grant lands
  // exactly `spacing` cycles after the current one.
  function automatic int cnt_load(input int spacing);
    return (spacing > 0) ? spacing - 1 : 0;
  endfunction

  // 1 when lane 1 should win a single-grant contest.
  function automatic logic favour_lane1(input int age0, input int age1,
                                        input logic k0, input logic k1);
    if (age1 != age0) return age1 > age0;
    if (k1 != k0)     return k1 == KIND_REFR;
    return 1'b0;
  endfunction

endpackage

// File: rtl/prech_gap_timer.sv
module prech_gap_timer
  import prech_pacer_pkg::*;
#(
  parameter int T_SAME    = 4,
  parameter int CROSS_EFF = 0,
  parameter int NSETS     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSETS-1:0] set_issue,
  output logic [NSETS-1:0] same_free,
  output logic [NSETS-1:0] cross_free
);
  localparam int CW = $clog2(T_SAME + 1);
  localparam logic [CW-1:0] SAME_LD  = CW'(cnt_load(T_SAME));
  localparam logic [CW-1:0] CROSS_LD = CW'(cnt_load(CROSS_EFF));

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic [CW-1:0] same_q, cross_q;
    logic          other_hit;

    assign other_hit     = |(set_issue & ~(NSETS'(1) << s));
    assign same_free[s]  = (same_q == '0);
    assign cross_free[s] = (cross_q == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        same_q  <= '0;
        cross_q <= '0;
      end else begin
        if (set_issue[s])      same_q <= SAME_LD;
        else if (same_q != '0) same_q <= same_q - 1'b1;
        if (other_hit)          cross_q <= CROSS_LD;
        else if (cross_q != '0) cross_q <= cross_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/prech_lane_age.sv
module prech_lane_age #(
  parameter int AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             waiting,
  input  logic             taken,
  output logic [AGE_W-1:0] age
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  age <= '0;
    else if (!waiting || taken)  age <= '0;
    else if (age != '1)          age <= age + 1'b1;
  end
endmodule

// File: rtl/prech_lane_arb.sv
module prech_lane_arb
  import prech_pacer_pkg::*;
#(
  parameter int MERGE_OK = 1,
  parameter int AGE_W    = 4
) (
  input  logic [1:0]       elig,
  input  logic [1:0]       lane_set,
  input  logic [1:0]       kind,
  input  logic [AGE_W-1:0] age0,
  input  logic [AGE_W-1:0] age1,
  output logic [1:0]       grant,
  output logic             merged
);
  logic pick1;

  always_comb begin
    pick1  = favour_lane1(int'(age0), int'(age1), kind[0], kind[1]);
    merged = (MERGE_OK != 0) && (&elig) && (lane_set[0] != lane_set[1]);
    if (merged)       grant = 2'b11;
    else if (&elig)   grant = pick1 ? 2'b10 : 2'b01;
    else              grant = elig;
  end
endmodule

// File: rtl/prech_pacer.sv
module prech_pacer
  import prech_pacer_pkg::*;
#(
  parameter int T_SAME   = 4,
  parameter int T_CROSS  = 0,
  parameter int ZERO_EN  = 1,
  parameter int DUAL_SET = 1,
  parameter int AGE_W    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_valid,
  input  logic [1:0] req_set,
  input  logic [1:0] req_kind,
  output logic [1:0] req_ready,
  output logic       pkt_valid,
  output logic [1:0] pkt_pre,
  output logic [1:0] pkt_kind
);
  localparam int CROSS_EFF = eff_cross(T_CROSS, ZERO_EN);
  localparam int MERGE_OK  = (CROSS_EFF == 0 && DUAL_SET != 0) ? 1 : 0;

  // Named internal events, visible to the bound checker.
  logic [1:0]       lane_set;
  logic [1:0]       lane_elig;
  logic [1:0]       lane_grant;
  logic [1:0]       set_issue;
  logic [1:0]       same_free, cross_free;
  logic             pkt_merge;
  logic [AGE_W-1:0] lane_age [2];

  assign lane_set = (DUAL_SET != 0) ? req_set : 2'b00;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign lane_elig[i] = req_valid[i] && same_free[lane_set[i]]
                          && cross_free[lane_set[i]];
    prech_lane_age #(.AGE_W(AGE_W)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (req_valid[i]),
      .taken   (lane_grant[i]),
      .age     (lane_age[i])
    );
  end

  for (genvar s = 0; s < 2; s++) begin : g_issue
    assign set_issue[s] = (lane_grant[0] && lane_set[0] == 1'(s))
                       || (lane_grant[1] && lane_set[1] == 1'(s));
  end

  prech_gap_timer #(.T_SAME(T_SAME), .CROSS_EFF(CROSS_EFF), .NSETS(2)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_issue  (set_issue),
    .same_free  (same_free),
    .cross_free (cross_free)
  );

  prech_lane_arb #(.MERGE_OK(MERGE_OK), .AGE_W(AGE_W)) u_arb (
    .elig     (lane_elig),
    .lane_set (lane_set),
    .kind     (req_kind),
    .age0     (lane_age[0]),
    .age1     (lane_age[1]),
    .grant    (lane_grant),
    .merged   (pkt_merge)
  );

  assign req_ready = lane_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_pre   <= 2'b00;
      pkt_kind  <= 2'b00;
    end else begin
      pkt_valid <= |lane_grant;
      pkt_pre   <= set_issue;
      for (int s = 0; s < 2; s++) begin
        if (lane_grant[0] && lane_set[0] == 1'(s))      pkt_kind[s] <= req_kind[0];
        else if (lane_grant[1] && lane_set[1] == 1'(s)) pkt_kind[s] <= req_kind[1];
        else                                            pkt_kind[s] <= KIND_NORM;
      end
    end
  end
endmodule

// File: rtl/prech_pacer_chk.sv
module prech_pacer_chk
  import prech_pacer_pkg::*;
#(
  parameter int T_SAME   = 4,
  parameter int T_CROSS  = 0,
  parameter int ZERO_EN  = 1,
  parameter int DUAL_SET = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_valid,
  input logic [1:0] req_ready,
  input logic       pkt_valid,
  input logic [1:0] pkt_pre,
  input logic [1:0] lane_grant,
  input logic [1:0] lane_set
);
  localparam int CROSS_EFF = eff_cross(T_CROSS, ZERO_EN);

  logic [7:0] since_q [2];

  for (genvar s = 0; s < 2; s++) begin : g_gap
    always_ff @(posedge clk) begin
      if (!rst_n)                     since_q[s] <= 8'hFF;
      else if (pkt_valid && pkt_pre[s]) since_q[s] <= 8'h00;
      else if (since_q[s] != 8'hFF)   since_q[s] <= since_q[s] + 8'h01;
    end

    // R1
    assert_same_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_pre[s]) |-> ({1'b0, since_q[s]} + 9'd1 >= 9'(T_SAME)));
    // R2, R3, R4, R6
    assert_cross_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_pre[s] && !pkt_pre[1-s])
        |-> ({1'b0, since_q[1-s]} + 9'd1 >= 9'(CROSS_EFF)));
  end

  assert_merge_only_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (&pkt_pre)) |-> (CROSS_EFF == 0));

  assert_no_same_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_grant) |-> (lane_set[0] != lane_set[1]));

  assert_ready_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == 2'b00);

  assert_pkt_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> pkt_valid);

  assert_pkt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_valid & req_ready)) |=> !pkt_valid);

  if (DUAL_SET == 0) begin : g_single
    assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> !pkt_pre[1]);
  end
endmodule

bind prech_pacer prech_pacer_chk #(
  .T_SAME(T_SAME), .T_CROSS(T_CROSS), .ZERO_EN(ZERO_EN), .DUAL_SET(DUAL_SET)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .pkt_valid  (pkt_valid),
  .pkt_pre    (pkt_pre),
  .lane_grant (lane_grant),
  .lane_set   (lane_set)
);

// File: tb/sim_prech_pacer.sv
module sim_prech_pacer;
  // Instance d: 0 cross0 merge, 1 cross1, 2 cross2, 3 cross4, 4 cross0 no merge, 5 single set
  localparam int N = 6;
  localparam int CR[N] = '{0, 1, 2, 4, 0, 0};
  localparam int ZE[N] = '{1, 1, 1, 1, 0, 1};
  localparam int DU[N] = '{1, 1, 1, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  int   nchk = 0;
  int   nfail = 0;

  logic [1:0] rv [N];
  logic [1:0] rs [N];
  logic [1:0] rk [N];
  wire  [1:0] rr [N];
  wire        pv [N];
  wire  [1:0] pp [N];
  wire  [1:0] pk [N];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prech_pacer #(.T_SAME(4), .T_CROSS(CR[0]), .ZERO_EN(ZE[0]), .DUAL_SET(DU[0])) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_set(rs[0]), .req_kind(rk[0]),
    .req_ready(rr[0]), .pkt_valid(pv[0]), .pkt_pre(pp[0]), .pkt_kind(pk[0]));

  for (genvar g = 1; g < N; g++) begin : g_sweep
    prech_pacer #(.T_SAME(4), .T_CROSS(CR[g]), .ZERO_EN(ZE[g]), .DUAL_SET(DU[g])) u_sw (
      .clk(clk), .rst_n(rst_n), .req_valid(rv[g]), .req_set(rs[g]), .req_kind(rk[g]),
      .req_ready(rr[g]), .pkt_valid(pv[g]), .pkt_pre(pp[g]), .pkt_kind(pk[g]));
  end

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(input int d, input int lane, input logic st, input logic kd,
                      output int t);
    rs[d][lane] = st;
    rk[d][lane] = kd;
    rv[d][lane] = 1'b1;
    forever begin
      #1;
      if (rr[d][lane]) begin
        t = cyc;
        @(negedge clk);
        rv[d][lane] = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    int t0, t1;
    chk("R11 pkt_valid idle after reset", int'(pv[0]), 0);
    #1 t0 = cyc;
    @(negedge clk);
    send(0, 0, 1'b0, 1'b0, t1);
    chk("R11 first request granted at once", t1 - t0, 1);
    chk("R10 packet valid", int'(pv[0]), 1);
    chk("R10 packet slot", int'(pp[0]), 1);
    chk("R10 packet kind", int'(pk[0]), 0);
    @(negedge clk);
    chk("R10 no packet without grant", int'(pv[0]), 0);
  endtask

  task automatic t_same();
    int ta, tb;
    for (int d = 0; d < 4; d++) begin
      settle();
      send(d, 0, 1'b1, 1'b0, ta);
      send(d, 0, 1'b1, 1'b1, tb);
      chk($sformatf("R1 same-set gap inst %0d", d), tb - ta, 4);
      chk("R10 refresh kind in slot 1", int'(pk[d]), 2);
    end
  endtask

  task automatic t_cross();
    int ta, tb;
    for (int d = 0; d < 4; d++) begin
      settle();
      send(d, 0, 1'b0, 1'b0, ta);
      send(d, 0, 1'b1, 1'b0, tb);
      chk($sformatf("R2 cross-set gap inst %0d", d), tb - ta, (CR[d] > 1) ? CR[d] : 1);
    end
  endtask

  task automatic t_sandwich();
    int ta, tb, tc;
    for (int d = 1; d < 4; d++) begin
      settle();
      send(d, 0, 1'b0, 1'b0, ta);
      send(d, 0, 1'b1, 1'b0, tb);
      send(d, 0, 1'b0, 1'b0, tc);
      if (d == 3) begin
        chk("R4 middle offset", tb - ta, 4);
        chk("R4 last offset", tc - ta, 8);
      end else begin
        chk($sformatf("R3 middle offset inst %0d", d), tb - ta, CR[d]);
        chk($sformatf("R3 last offset inst %0d", d), tc - ta, 4);
      end
    end
  endtask

  task automatic t_merge();
    int rdy;
    settle();
    rs[0] = 2'b10; rk[0] = 2'b10; rv[0] = 2'b11;
    #1 rdy = int'(rr[0]);
    @(negedge clk);
    rv[0] = 2'b00;
    chk("R5 both lanes granted together", rdy, 3);
    chk("R5 merged packet valid", int'(pv[0]), 1);
    chk("R5 merged packet slots", int'(pp[0]), 3);
    chk("R5 merged packet kinds", int'(pk[0]), 2);
  endtask

  task automatic t_nozero();
    int t0, t1;
    settle();
    fork
      send(4, 0, 1'b0, 1'b0, t0);
      send(4, 1, 1'b1, 1'b1, t1);
    join
    chk("R6 zero mode off gives 1-cycle gap", t0 - t1, 1);
  endtask

  task automatic t_same_nomerge();
    int t0, t1;
    settle();
    fork
      send(0, 0, 1'b0, 1'b0, t0);
      send(0, 1, 1'b0, 1'b1, t1);
    join
    chk("R7 same set not merged, refresh first", t0 - t1, 4);
  endtask

  task automatic t_single();
    int ta, tb;
    settle();
    send(5, 0, 1'b0, 1'b0, ta);
    send(5, 0, 1'b1, 1'b0, tb);
    chk("R8 single set ignores set bit gap", tb - ta, 4);
    chk("R8 single set uses slot 0", int'(pp[5]), 1);
  endtask

  task automatic t_age();
    int ta, t0, t1;
    settle();
    send(3, 0, 1'b0, 1'b0, ta);
    fork
      send(3, 1, 1'b1, 1'b0, t1);
      begin
        @(negedge clk);
        send(3, 0, 1'b0, 1'b1, t0);
      end
    join
    chk("R9 older lane 1 first", t1 - ta, 4);
    chk("R9 younger refresh waits", t0 - ta, 8);
  endtask

  initial begin
    for (int d = 0; d < N; d++) begin
      rv[d] = 2'b00; rs[d] = 2'b00; rk[d] = 2'b00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_same();
    t_cross();
    t_sandwich();
    t_merge();
    t_nozero();
    t_same_nomerge();
    t_single();
    t_age();
    settle();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule